// File: doc/BRIEF.md
# Flash Region Lock and Command Guard

This block stands between a command register interface and the flash array sequencer. Each command carries an opcode and a page number. Page program and page erase commands are passed to the sequencer only when the target page is writable. The flash is split into sixteen equal regions, and each region has its own lock bit. Pages at the bottom of the array hold the boot loader and have a separate protection bit. A device security bit stops software from lowering protection once it is set.

A violating command never reaches the array. Instead it sets a sticky error flag, which stays set until a dedicated command clears it. Chip erase is the one path that removes all protection. It runs two array steps in a fixed order: first a wipe of all volatile memories, then an erase of the whole flash. Only after the second step completes are the security bit, the boot protection and every region lock cleared.

The block reports busy while an array operation is in flight. While busy it drops any command presented to it.

Top module: `flash_guard`

## Requirements
- R1: After reset, lock_bits is all zero, boot_locked, secure, lock_err, busy and arr_req are 0.
- R2: Opcode 3 sets and opcode 4 clears the lock bit of region cmd_page >> (log2(PAGES) - 4), visible one cycle after acceptance, without raising busy.
- R3: Opcode 1 (program) or 2 (erase page) to a writable page produces a one-cycle arr_req in the next cycle with arr_op 0 or 1 respectively and arr_page equal to cmd_page; busy rises with it and falls in the cycle after seq_done.
- R4: Opcode 1 or 2 to a page whose region is locked issues no arr_req, leaves busy low and sets lock_err, which stays set.
- R5: Opcode 5 sets and opcode 6 clears boot_locked; while it is set, program or erase of a page below BOOT_PAGES is rejected as in R4 even when its region is unlocked, while pages at or above BOOT_PAGES are unaffected.
- R6: Opcode 7 sets secure; while secure, opcodes 4 and 6 change nothing and set lock_err.
- R7: Opcode 8 (chip erase), regardless of locks, issues arr_req with arr_op 2 (volatile wipe) in the next cycle, then arr_op 3 (whole flash erase) in the cycle after the first seq_done; the cycle after the second seq_done has lock_bits, boot_locked and secure all cleared and busy low.
- R8: While busy, cmd_valid has no effect, including in the cycle where seq_done arrives.
- R9: Opcode 9 clears lock_err; seq_done while not busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 4 | Command opcode |
| cmd_page | input | log2(PAGES) | Target page number |
| seq_done | input | 1 | Sequencer finished the current array step |
| busy | output | 1 | Array operation in flight, commands dropped |
| lock_err | output | 1 | Sticky protection violation flag |
| lock_bits | output | 16 | Region lock bits |
| boot_locked | output | 1 | Boot-loader page protection |
| secure | output | 1 | Device security bit |
| arr_req | output | 1 | One-cycle request to the sequencer |
| arr_op | output | 2 | 0 program, 1 page erase, 2 volatile wipe, 3 flash erase |
| arr_page | output | log2(PAGES) | Page for the request |

## Verification
The completion of an array step and a new command can land in the same cycle. At that point busy is still high, so the command must be lost, even though busy drops one cycle later. The bench raises seq_done and a lock command together and then reads lock_bits and busy to confirm that only the completion took effect. A scoreboard queue holds every expected sequencer request, so any request leaking out of a dropped or rejected command shows up as an unexpected entry.

// File: rtl/flash_guard.sv
module flash_guard #(
  parameter int PAGES = 512,
  parameter int BOOT_PAGES = 8,
  localparam int PW = $clog2(PAGES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [3:0]    cmd_op,
  input  logic [PW-1:0] cmd_page,
  input  logic          seq_done,
  output logic          busy,
  output logic          lock_err,
  output logic [15:0]   lock_bits,
  output logic          boot_locked,
  output logic          secure,
  output logic          arr_req,
  output logic [1:0]    arr_op,
  output logic [PW-1:0] arr_page
);
  typedef enum logic [1:0] {S_IDLE, S_PAGE, S_WIPE, S_FLASH} state_t;
  state_t state;

  wire [3:0] region   = cmd_page[PW-1 -: 4];
  wire       take     = cmd_valid && state == S_IDLE;
  wire       is_mod   = cmd_op == 4'd1 || cmd_op == 4'd2;
  wire       in_boot  = cmd_page < PW'(BOOT_PAGES);
  wire       guarded  = lock_bits[region] || (boot_locked && in_boot);

  assign busy = state != S_IDLE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      lock_err    <= 1'b0;
      lock_bits   <= '0;
      boot_locked <= 1'b0;
      secure      <= 1'b0;
      arr_req     <= 1'b0;
      arr_op      <= 2'd0;
      arr_page    <= '0;
    end else begin
      arr_req <= 1'b0;
      case (state)
        S_PAGE:  if (seq_done) state <= S_IDLE;
        S_WIPE:  if (seq_done) begin
                   state   <= S_FLASH;
                   arr_req <= 1'b1;
                   arr_op  <= 2'd3;
                 end
        S_FLASH: if (seq_done) begin
                   state       <= S_IDLE;
                   lock_bits   <= '0;
                   boot_locked <= 1'b0;
                   secure      <= 1'b0;
                 end
        default: ;
      endcase
      if (take) begin
        case (cmd_op)
          4'd1, 4'd2: begin
            if (guarded) lock_err <= 1'b1;
            else begin
              state    <= S_PAGE;
              arr_req  <= 1'b1;
              arr_op   <= (cmd_op == 4'd1) ? 2'd0 : 2'd1;
              arr_page <= cmd_page;
            end
          end
          4'd3: lock_bits[region] <= 1'b1;
          4'd4: if (secure) lock_err <= 1'b1;
                else lock_bits[region] <= 1'b0;
          4'd5: boot_locked <= 1'b1;
          4'd6: if (secure) lock_err <= 1'b1;
                else boot_locked <= 1'b0;
          4'd7: secure <= 1'b1;
          4'd8: begin
            state    <= S_WIPE;
            arr_req  <= 1'b1;
            arr_op   <= 2'd2;
            arr_page <= '0;
          end
          4'd9: lock_err <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  a_r4_locked_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    take && is_mod && lock_bits[region] |=> lock_err && !arr_req && !busy);

  a_r5_boot_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    take && is_mod && boot_locked && in_boot |=> !arr_req && lock_err);

  a_r6_secure_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    take && secure && cmd_op == 4'd4 |=> $stable(lock_bits) && lock_err);

  a_r7_erase_order: assert property (@(posedge clk) disable iff (!rst_n)
    arr_req && arr_op == 2'd3 |-> $past(seq_done) && $past(state) == S_WIPE);

  a_r7_secure_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(secure) |-> $past(seq_done) && $past(state) == S_FLASH);

  a_r8_busy_drops: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cmd_valid && !seq_done |=> $stable(lock_bits) && $stable(boot_locked));

  a_r3_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
    arr_req |-> busy);
endmodule

// File: tb/flash_guard_bench.sv
module flash_guard_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 9;

  logic clk = 0, rst_n = 0, cmd_valid = 0, seq_done = 0;
  logic [3:0] cmd_op = 0;
  logic [PW-1:0] cmd_page = 0;
  logic busy, lock_err, boot_locked, secure, arr_req;
  logic [15:0] lock_bits;
  logic [1:0] arr_op;
  logic [PW-1:0] arr_page;

  int checks = 0, fails = 0;
  logic [PW+1:0] expq[$];

  flash_guard #(.PAGES(512), .BOOT_PAGES(8)) u_flash_guard (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_page(cmd_page), .seq_done(seq_done), .busy(busy), .lock_err(lock_err),
    .lock_bits(lock_bits), .boot_locked(boot_locked), .secure(secure),
    .arr_req(arr_req), .arr_op(arr_op), .arr_page(arr_page));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && arr_req) begin
    if (expq.size() == 0) chk(0, "R4/R8 unexpected request", {arr_op, arr_page}, 0);
    else begin
      logic [PW+1:0] e;
      e = expq.pop_front();
      chk({arr_op, arr_page} == e, "R3/R7 request", {arr_op, arr_page}, e);
    end
  end

  task automatic issue(input logic [3:0] op, input int page);
    cmd_valid = 1; cmd_op = op; cmd_page = PW'(page);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic expect_req(input logic [1:0] op, input int page);
    expq.push_back({op, PW'(page)});
  endtask

  task automatic done();
    seq_done = 1;
    @(negedge clk);
    seq_done = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    chk(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(lock_bits == 0 && !boot_locked && !secure && !lock_err && !busy && !arr_req,
        "R1 reset state", {lock_bits, boot_locked, secure, lock_err, busy}, 0);

    expect_req(2'd0, 100);
    issue(4'd1, 100);
    chk(busy, "R3 busy after program", busy, 1);
    issue(4'd3, 100);
    chk(lock_bits == 0, "R8 lock ignored while busy", lock_bits, 0);
    cmd_valid = 1; cmd_op = 4'd3; cmd_page = 9'd100;
    done();
    cmd_valid = 0;
    chk(!busy && lock_bits == 0, "R8 command in seq_done cycle dropped", {lock_bits, busy}, 0);

    issue(4'd3, 100);
    chk(lock_bits == 16'h0008 && !busy, "R2 lock region 3", lock_bits, 16'h0008);
    issue(4'd1, 110);
    chk(lock_err && !busy, "R4 program into locked region", {lock_err, busy}, 2);
    issue(4'd9, 0);
    chk(!lock_err, "R9 clear error", lock_err, 0);
    issue(4'd2, 96);
    chk(lock_err && !busy, "R4 erase into locked region", {lock_err, busy}, 2);
    @(negedge clk);
    chk(lock_err, "R4 error stays set", lock_err, 1);
    issue(4'd9, 0);
    done();
    chk(!busy && !lock_err, "R9 idle seq_done no effect", {busy, lock_err}, 0);

    issue(4'd4, 100);
    chk(lock_bits == 0, "R2 unlock region 3", lock_bits, 0);
    expect_req(2'd1, 100);
    issue(4'd2, 100);
    chk(busy, "R3 busy after erase", busy, 1);
    done();
    chk(!busy, "R3 busy falls after done", busy, 0);

    issue(4'd5, 0);
    chk(boot_locked, "R5 boot lock set", boot_locked, 1);
    issue(4'd1, 3);
    chk(lock_err && !busy, "R5 boot page rejected", {lock_err, busy}, 2);
    issue(4'd9, 0);
    expect_req(2'd0, 20);
    issue(4'd1, 20);
    chk(busy && !lock_err, "R5 page above boot area allowed", {busy, lock_err}, 2);
    done();

    issue(4'd3, 480);
    issue(4'd7, 0);
    chk(secure && lock_bits == 16'h8000, "R6 security set", {secure, lock_bits}, 17'h18000);
    issue(4'd4, 480);
    chk(lock_bits == 16'h8000 && lock_err, "R6 unlock refused when secure", {lock_err, lock_bits}, 17'h18000);
    issue(4'd6, 0);
    chk(boot_locked, "R6 boot unlock refused when secure", boot_locked, 1);

    expect_req(2'd2, 0);
    issue(4'd8, 0);
    chk(busy && secure, "R7 chip erase started", {busy, secure}, 3);
    expect_req(2'd3, 0);
    done();
    chk(busy && lock_bits == 16'h8000, "R7 flash step, locks held", {busy, lock_bits}, 17'h18000);
    done();
    chk(!busy && lock_bits == 0 && !boot_locked && !secure, "R7 chip erase end state",
        {busy, lock_bits, boot_locked, secure}, 0);

    repeat (2) @(negedge clk);
    chk(expq.size() == 0, "R3/R7 all requests seen", expq.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule